// File: doc/BRIEF.md
# Truncating Float-to-Int32 Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. Its fractional part is always discarded toward zero. The operand arrives as a class code, a sign bit, a signed unbiased exponent and a significand whose leading one is explicit. The block returns the integer together with two flags. The inexact flag reports that fractional bits were thrown away. The invalid flag reports that the value could not be represented.

Values that fall outside the signed 32-bit range saturate to the limit on their own side. Infinities and NaNs also saturate. In every saturating case, invalid replaces inexact. The datapath is a two-stage pipeline with a single valid bit, so a new operand can be accepted on every cycle.

Top module: `f2i_trunc`

## Requirements
- R1: An operand with class code 0 (zero) yields result 0 with both flags clear, whatever its sign, exponent and significand.
- R2: A normal operand (class code 1) has the value in_sig × 2^(in_exp − 52), with bit 52 of in_sig as the leading one. When that value is in range, the result is its magnitude truncated toward zero, and it is negated when in_sign is 1.
- R3: For an in-range normal operand, inexact is set exactly when a nonzero bit was discarded. The magnitude is never incremented, so positive 2.75 gives 2.
- R4: A normal operand with a negative exponent yields 0 with inexact set, for either sign.
- R5: A normal operand whose exponent is 32 or greater is treated as out of range.
- R6: A truncated magnitude is out of range when it is at least 0x80000000 plus the sign bit. A negative operand that truncates to magnitude 0x80000000 therefore gives 0x80000000 with invalid clear. The positive value 2^31 is out of range.
- R7: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN), and the unused codes 5 to 7, are always out of range.
- R8: An out-of-range operand yields 0x7FFFFFFF when in_sign is 0 and 0x80000000 when in_sign is 1. Invalid is set and inexact is clear.
- R9: The result and flags for an operand accepted with in_valid appear exactly two cycles later, with out_valid high. Operands on consecutive cycles come out on consecutive cycles, and out_valid is low otherwise.
- R10: While rst_n is low at a clock edge, out_valid, out_result, out_inexact and out_invalid are all cleared.
- R11: Exponents far below zero, down to −2048, give 0 with inexact set. The alignment shift does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 12 | Unbiased exponent, two's complement |
| in_sig | input | 53 | Significand, leading one at bit 52 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Two's-complement integer result |
| out_inexact | output | 1 | Nonzero fractional bits were discarded |
| out_invalid | output | 1 | Operand was out of range, infinite or NaN |

## Verification
Some properties are checked on every cycle. Invalid and inexact never rise together. Every saturated result is one of the two limits. A nonzero in-range result carries the operand's sign in its top bit. A zero operand produces a clean zero. The valid bit moves through the pipeline one stage per cycle. Other behaviour can only be shown by the directed scenarios, because it depends on the actual arithmetic value: the exact truncated integers, the one-sided boundary at 2^31, the absence of rounding up, and the shift behaviour for extreme negative exponents.

// File: rtl/f2i_pkg.sv
// Package: shared widths and the operand class encoding for the
// float-to-integer converter. Assumes SIG_W > INT_W.
package f2i_pkg;
    localparam int INT_W = 32;
    localparam int EXP_W = 12;
    localparam int SIG_W = 53;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } f2i_class_e;
endpackage

// File: rtl/f2i_prep.sv
// Module: f2i_prep
// Decodes the operand class and exponent. Produces the flags for the
// zero and forced-overflow paths, and a right-shift amount that is clamped
// to [0, SIG_W]. Assumes the significand's leading one sits at bit SIG_W-1.
module f2i_prep #(
    parameter int INT_W = 32,
    parameter int EXP_W = 12,
    parameter int SIG_W = 53,
    localparam int SH_W = $clog2(SIG_W + 1)
) (
    input  logic [2:0]             cls,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic                   is_zero,
    output logic                   force_ovf,
    output logic [SH_W-1:0]        shamt
);
    import f2i_pkg::*;

    localparam int LEAD = SIG_W - 1;

    int sh_raw;

    // Classify: zero passes clean, non-normals and large exponents overflow.
    always_comb begin
        is_zero   = (cls == CLS_ZERO);
        force_ovf = 1'b0;
        if (cls != CLS_ZERO) begin
            if (cls != CLS_NORM)
                force_ovf = 1'b1;
            else if (int'(exp_in) >= INT_W)
                force_ovf = 1'b1;
        end
    end

    // Shift amount: clamp at zero below and at SIG_W above, so it never wraps.
    always_comb begin
        sh_raw = LEAD - int'(exp_in);
        if (sh_raw < 0)
            shamt = '0;
        else if (sh_raw > SIG_W)
            shamt = SH_W'(SIG_W);
        else
            shamt = SH_W'(sh_raw);
    end
endmodule

// File: rtl/f2i_align.sv
// Module: f2i_align
// Right-shifts the significand so that its integer part lands in INT_W bits.
// Everything shifted out is ORed into a sticky bit, and a flag reports
// integer bits that do not fit in INT_W. Combinational.
module f2i_align #(
    parameter int INT_W = 32,
    parameter int SIG_W = 53,
    localparam int SH_W = $clog2(SIG_W + 1)
) (
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [INT_W-1:0] mag,
    output logic             hi_nz,
    output logic             sticky
);
    logic [SIG_W-1:0] shifted;
    logic [SIG_W-1:0] lost_mask;

    // Barrel shift and collection of the discarded bits.
    always_comb begin
        shifted   = sig >> shamt;
        lost_mask = ~({SIG_W{1'b1}} << shamt);
        mag       = shifted[INT_W-1:0];
        hi_nz     = |shifted[SIG_W-1:INT_W];
        sticky    = |(sig & lost_mask);
    end
endmodule

// File: rtl/f2i_resolve.sv
// Module: f2i_resolve
// Second pipeline stage. Performs the signed range check, saturation or
// negation, and flag selection, and registers the outputs.
// Assumes its inputs come from the first-stage registers.
module f2i_resolve #(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             s_sign,
    input  logic             s_zero,
    input  logic             s_force,
    input  logic             s_hi_nz,
    input  logic [INT_W-1:0] s_mag,
    input  logic             s_sticky,
    output logic             o_valid,
    output logic [INT_W-1:0] o_result,
    output logic             o_inexact,
    output logic             o_invalid
);
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W:0]   limit;
    logic             ovf;
    logic [INT_W-1:0] res_d;
    logic             inx_d;
    logic             inv_d;
    logic             sign_q;

    // Range check: magnitude must stay below 2^(INT_W-1) plus the sign bit.
    always_comb begin
        limit = {2'b01, {(INT_W-1){1'b0}}} + {{INT_W{1'b0}}, s_sign};
        ovf   = !s_zero && (s_force || s_hi_nz || ({1'b0, s_mag} >= limit));
    end

    // Result select: zero, saturation limit, or the signed magnitude.
    always_comb begin
        if (s_zero) begin
            res_d = '0;
            inx_d = 1'b0;
            inv_d = 1'b0;
        end else if (ovf) begin
            res_d = s_sign ? NEG_MIN : POS_MAX;
            inx_d = 1'b0;
            inv_d = 1'b1;
        end else begin
            res_d = s_sign ? (~s_mag + 1'b1) : s_mag;
            inx_d = s_sticky;
            inv_d = 1'b0;
        end
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid   <= 1'b0;
            o_result  <= '0;
            o_inexact <= 1'b0;
            o_invalid <= 1'b0;
            sign_q    <= 1'b0;
        end else begin
            o_valid   <= s_valid;
            sign_q    <= s_sign;
            if (s_valid) begin
                o_result  <= res_d;
                o_inexact <= inx_d;
                o_invalid <= inv_d;
            end
        end
    end

    // R8: invalid replaces inexact, never both.
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> !(o_invalid && o_inexact));

    // R8: a saturated result is always one of the two limits.
    p_sat_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_invalid) |-> (o_result == POS_MAX || o_result == NEG_MIN));

    // R1: a zero-class operand leaves a clean zero.
    p_zero_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_zero) |=> (o_result == '0 && !o_inexact && !o_invalid));

    // R2: a nonzero in-range result carries the operand sign.
    p_sign_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_invalid && o_result != '0) |-> (o_result[INT_W-1] == sign_q));
endmodule

// File: rtl/f2i_trunc.sv
// Module: f2i_trunc (top)
// Float-to-signed-integer conversion with truncation toward zero.
// Stage 1 decodes and aligns the operand; stage 2 checks range, saturates or
// negates, and selects the flags. Latency is two cycles and an operand may be
// accepted every cycle. Assumes SIG_W > INT_W and a leading one at SIG_W-1.
module f2i_trunc
    import f2i_pkg::*;
#(
    parameter int P_INT_W = INT_W,
    parameter int P_EXP_W = EXP_W,
    parameter int P_SIG_W = SIG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               in_class,
    input  logic                     in_sign,
    input  logic signed [P_EXP_W-1:0] in_exp,
    input  logic [P_SIG_W-1:0]       in_sig,
    output logic                     out_valid,
    output logic [P_INT_W-1:0]       out_result,
    output logic                     out_inexact,
    output logic                     out_invalid
);
    localparam int SH_W = $clog2(P_SIG_W + 1);

    logic               d_zero, d_force;
    logic [SH_W-1:0]    d_shamt;
    logic [P_INT_W-1:0] d_mag;
    logic               d_hi_nz, d_sticky;

    logic               s1_valid, s1_sign, s1_zero, s1_force, s1_hi_nz, s1_sticky;
    logic [P_INT_W-1:0] s1_mag;

    f2i_prep #(.INT_W(P_INT_W), .EXP_W(P_EXP_W), .SIG_W(P_SIG_W)) u_prep (
        .cls       (in_class),
        .exp_in    (in_exp),
        .is_zero   (d_zero),
        .force_ovf (d_force),
        .shamt     (d_shamt)
    );

    f2i_align #(.INT_W(P_INT_W), .SIG_W(P_SIG_W)) u_align (
        .sig    (in_sig),
        .shamt  (d_shamt),
        .mag    (d_mag),
        .hi_nz  (d_hi_nz),
        .sticky (d_sticky)
    );

    // Stage 1 registers: aligned magnitude and the decode results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sign   <= 1'b0;
            s1_zero   <= 1'b0;
            s1_force  <= 1'b0;
            s1_hi_nz  <= 1'b0;
            s1_sticky <= 1'b0;
            s1_mag    <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_sign   <= in_sign;
            s1_zero   <= d_zero;
            s1_force  <= d_force;
            s1_hi_nz  <= d_hi_nz;
            s1_sticky <= d_sticky;
            s1_mag    <= d_mag;
        end
    end

    f2i_resolve #(.INT_W(P_INT_W)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s1_valid),
        .s_sign    (s1_sign),
        .s_zero    (s1_zero),
        .s_force   (s1_force),
        .s_hi_nz   (s1_hi_nz),
        .s_mag     (s1_mag),
        .s_sticky  (s1_sticky),
        .o_valid   (out_valid),
        .o_result  (out_result),
        .o_inexact (out_inexact),
        .o_invalid (out_invalid)
    );

    // R9: the valid bit advances one stage per cycle.
    p_valid_s1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    p_valid_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
endmodule

// File: tb/tb_f2i_trunc.sv
// Directed bench for f2i_trunc: one task per scenario, each checking its results.
module tb_f2i_trunc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_class = 3'd0;
    logic        in_sign = 1'b0;
    logic signed [11:0] in_exp = '0;
    logic [52:0] in_sig = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_inexact;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    f2i_trunc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    localparam logic [52:0] ONE = 53'd1 << 52;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic drive(logic [2:0] c, logic s, int e, logic [52:0] m);
        in_valid = 1'b1;
        in_class = c;
        in_sign  = s;
        in_exp   = 12'(e);
        in_sig   = m;
    endtask

    task automatic expect_out(string tag, logic [31:0] r, logic inx, logic inv);
        chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " result"}, out_result, r);
        chk({tag, " inexact"}, {31'd0, out_inexact}, {31'd0, inx});
        chk({tag, " invalid"}, {31'd0, out_invalid}, {31'd0, inv});
    endtask

    // One operand through the two-stage pipeline, checked after the second edge.
    task automatic run_one(string tag, logic [2:0] c, logic s, int e, logic [52:0] m,
                           logic [31:0] r, logic inx, logic inv);
        drive(c, s, e, m);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        expect_out(tag, r, inx, inv);
        @(negedge clk);
        chk({tag, " valid drops"}, {31'd0, out_valid}, 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 valid", {31'd0, out_valid}, 32'd0);
        chk("R10 result", out_result, 32'd0);
        chk("R10 flags", {30'd0, out_inexact, out_invalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_zero();
        run_one("R1 +zero", 3'd0, 1'b0, 0, '0, 32'd0, 1'b0, 1'b0);
        run_one("R1 -zero junk", 3'd0, 1'b1, 40, {53{1'b1}}, 32'd0, 1'b0, 1'b0);
    endtask

    task automatic test_exact();
        run_one("R2 one", 3'd1, 1'b0, 0, ONE, 32'd1, 1'b0, 1'b0);
        run_one("R2 12345", 3'd1, 1'b0, 13, 53'(12345) << 39, 32'd12345, 1'b0, 1'b0);
        run_one("R2 -12345", 3'd1, 1'b1, 13, 53'(12345) << 39, -32'sd12345, 1'b0, 1'b0);
    endtask

    task automatic test_truncate();
        run_one("R3 1.5", 3'd1, 1'b0, 0, 53'(3) << 51, 32'd1, 1'b1, 1'b0);
        run_one("R3 +2.75", 3'd1, 1'b0, 1, 53'(11) << 49, 32'd2, 1'b1, 1'b0);
        run_one("R3 -2.75", 3'd1, 1'b1, 1, 53'(11) << 49, 32'hFFFF_FFFE, 1'b1, 1'b0);
        run_one("R3 max-0.5", 3'd1, 1'b0, 30, 53'(32'hFFFF_FFFF) << 21,
                32'h7FFF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic test_small();
        run_one("R4 +0.5", 3'd1, 1'b0, -1, ONE, 32'd0, 1'b1, 1'b0);
        run_one("R4 -0.5", 3'd1, 1'b1, -1, ONE, 32'd0, 1'b1, 1'b0);
        run_one("R11 exp -60", 3'd1, 1'b0, -60, {53{1'b1}}, 32'd0, 1'b1, 1'b0);
        run_one("R11 exp -2048", 3'd1, 1'b1, -2048, ONE, 32'd0, 1'b1, 1'b0);
    endtask

    task automatic test_boundary();
        run_one("R6 -2^31", 3'd1, 1'b1, 31, ONE, 32'h8000_0000, 1'b0, 1'b0);
        run_one("R6 -2^31-0.5", 3'd1, 1'b1, 31, ONE | (53'd1 << 20),
                32'h8000_0000, 1'b1, 1'b0);
        run_one("R6 +2^31", 3'd1, 1'b0, 31, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1);
        run_one("R6 -(2^32-1)", 3'd1, 1'b1, 31, {53{1'b1}}, 32'h8000_0000, 1'b0, 1'b1);
        run_one("R5 exp 32", 3'd1, 1'b0, 32, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1);
        run_one("R5 exp 2047", 3'd1, 1'b1, 2047, ONE, 32'h8000_0000, 1'b0, 1'b1);
    endtask

    task automatic test_special();
        run_one("R7 +inf", 3'd2, 1'b0, 0, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1);
        run_one("R7 -qnan", 3'd3, 1'b1, 5, ONE, 32'h8000_0000, 1'b0, 1'b1);
        run_one("R7 snan", 3'd4, 1'b0, -3, ONE, 32'h7FFF_FFFF, 1'b0, 1'b1);
        run_one("R8 code 6", 3'd6, 1'b1, 0, '0, 32'h8000_0000, 1'b0, 1'b1);
    endtask

    // Three operands on consecutive cycles come out on consecutive cycles.
    task automatic test_stream();
        drive(3'd1, 1'b0, 2, ONE);                 // 4
        @(negedge clk);
        drive(3'd2, 1'b1, 0, ONE);                 // -inf
        @(negedge clk);
        drive(3'd1, 1'b1, 0, 53'(3) << 51);        // -1.5
        expect_out("R9 stream a", 32'd4, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R9 stream b", 32'h8000_0000, 1'b0, 1'b1);
        @(negedge clk);
        expect_out("R9 stream c", 32'hFFFF_FFFF, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 idle", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_zero();
        test_exact();
        test_truncate();
        test_small();
        test_boundary();
        test_special();
        test_stream();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule